// File: doc/BRIEF.md
# Segmented Bit-Line Steering with Clear-State Checking

This block sits between a word-wide data path and a storage array whose bit lines are cut into several short segments, one per sub-array. On the write side, a demultiplexer sends the write word to the one segment named by the upper address bits. It holds every other segment at all-zero, which is the cleared state. On the read side, a multiplexer built from a tree of 2-to-1 stages passes the word from the one selected segment.

The read multiplexer is lossless only if every input it does not pass is already clear. The block therefore does not accept a stray non-zero value on an unselected read segment silently: it raises an error flag. Each side also receives a late copy of its select, which the recovery half of the operation uses. The block compares that late copy with the select it captured at the start of the operation and flags any difference.

Each operation takes two clock cycles, one per phase. In the first cycle the request is sampled (evaluate). In the second cycle the result is on the outputs and the late select is compared (recovery). A new operation may start on every cycle.

Top module: `bitline_seg_steer`

## Requirements
- R1: While rst_n is low at a clock edge, every write segment output, rd_data, rd_clr_err, wr_dly_err and rd_dly_err are zero in the following cycle.
- R2: In the cycle after a clock edge that samples wr_go high, segment number wr_sel carries wr_data on bits [i*DATA_W +: DATA_W] of seg_wr_data, and the other segments are all zero.
- R3: In the cycle after a clock edge that samples wr_go low, every segment of seg_wr_data is zero, whatever wr_sel and wr_data were.
- R4: In the cycle after a clock edge that samples rd_go high, rd_data equals segment number rd_sel of seg_rd_data, with segment i on bits [i*DATA_W +: DATA_W].
- R5: In the cycle after a clock edge that samples rd_go low, rd_data is zero and rd_clr_err is low, whatever the read segments hold.
- R6: In the cycle after a clock edge that samples rd_go high, rd_clr_err is high exactly when at least one segment other than rd_sel was non-zero at that edge. The value of the selected segment never sets it.
- R7: In the cycle after a write is sampled, wr_dly_err is high exactly when wr_sel_dly differs from the captured wr_sel. In every other cycle it is low.
- R8: In the cycle after a read is sampled, rd_dly_err is high exactly when rd_sel_dly differs from the captured rd_sel. In every other cycle it is low.
- R9: Operations issued on consecutive cycles each produce their own result one cycle later, with no gap and no carry-over of the earlier segment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cycle is one phase |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_go | input | 1 | Starts a write steering operation |
| wr_sel | input | SEL_W | Segment chosen for the write |
| wr_data | input | DATA_W | Word to place on the chosen write segment |
| wr_sel_dly | input | SEL_W | Late copy of the write select, compared in the recovery cycle |
| seg_wr_data | output | NUM_SEG*DATA_W | Write segment lines, segment i on bits [i*DATA_W +: DATA_W] |
| wr_dly_err | output | 1 | Late write select disagrees with the captured select |
| rd_go | input | 1 | Starts a read steering operation |
| rd_sel | input | SEL_W | Segment chosen for the read |
| rd_sel_dly | input | SEL_W | Late copy of the read select, compared in the recovery cycle |
| seg_rd_data | input | NUM_SEG*DATA_W | Read segment lines, segment i on bits [i*DATA_W +: DATA_W] |
| rd_data | output | DATA_W | Word from the selected read segment |
| rd_clr_err | output | 1 | An unselected read segment was not clear |
| rd_dly_err | output | 1 | Late read select disagrees with the captured select |

## Verification
The bench builds the block with its defaults: an 8-bit word and a 2-bit select, which gives four segments and a multiplexer tree two stages deep. With two stages, a stray bit can be placed either in the sibling of the selected segment, which the first-level stage must catch, or in the far pair, which only the root stage sees. Both placements are exercised. All four segment indices are driven on both sides, and each late select is tested in matching, differing and idle cycles.

// File: rtl/bls_pkg.sv
// Shared defaults for the segmented bit-line steering block.
// Assumes the segment count is a power of two derived from the select width.
package bls_pkg;
    parameter int unsigned BLS_DATA_W = 8;
    parameter int unsigned BLS_SEL_W  = 2;
endpackage

// File: rtl/seg_wr_demux.sv
// Registered 1-to-N write demultiplexer. The selected segment receives the
// word and every other segment is driven to the cleared (all-zero) state.
// Assumes: wr_go sampled at the clock edge; result valid for one cycle.
module seg_wr_demux #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned SEL_W  = 2,
    localparam int unsigned NUM_SEG = 1 << SEL_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        go,
    input  logic [SEL_W-1:0]            sel,
    input  logic [DATA_W-1:0]           data,
    output logic [NUM_SEG*DATA_W-1:0]   seg_out
);
    for (genvar i = 0; i < NUM_SEG; i++) begin : g_seg
        logic [DATA_W-1:0] seg_q;
        // Load the word into this segment only when it is the chosen one.
        always_ff @(posedge clk) begin
            if (!rst_n)
                seg_q <= '0;
            else if (go && (sel == SEL_W'(i)))
                seg_q <= data;
            else
                seg_q <= '0;
        end
        assign seg_out[i*DATA_W +: DATA_W] = seg_q;
    end
endmodule

// File: rtl/seg_mux2.sv
// One 2-to-1 stage of the conditional read multiplexer. When sel is high
// in_a is passed and in_b must be clear; when low the roles swap. The stage
// reports a violation if the input it does not pass is non-zero.
module seg_mux2 #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              sel,
    input  logic [DATA_W-1:0] in_a,
    input  logic [DATA_W-1:0] in_b,
    output logic [DATA_W-1:0] out,
    output logic              viol
);
    // Pass one input and test the other for the cleared state.
    always_comb begin
        out  = sel ? in_a : in_b;
        viol = sel ? (|in_b) : (|in_a);
    end
endmodule

// File: rtl/seg_rd_tree.sv
// N-to-1 read multiplexer built as a binary tree of seg_mux2 stages.
// Heap layout: node k has children 2k+1 (lower segments) and 2k+2 (upper).
// The root uses the select MSB. The OR of every stage's violation is exactly
// "some unselected segment is non-zero".
module seg_rd_tree #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned SEL_W  = 2,
    localparam int unsigned NUM_SEG = 1 << SEL_W,
    localparam int unsigned NODES   = 2 * NUM_SEG - 1
) (
    input  logic [SEL_W-1:0]          sel,
    input  logic [NUM_SEG*DATA_W-1:0] seg_in,
    output logic [DATA_W-1:0]         out,
    output logic                      any_viol
);
    logic [DATA_W-1:0]    node [NODES];
    logic [NUM_SEG-2:0]   viol;

    for (genvar j = 0; j < NUM_SEG; j++) begin : g_leaf
        assign node[NUM_SEG-1+j] = seg_in[j*DATA_W +: DATA_W];
    end

    for (genvar d = 0; d < SEL_W; d++) begin : g_lvl
        for (genvar p = 0; p < (1 << d); p++) begin : g_pos
            localparam int unsigned K = (1 << d) - 1 + p;
            seg_mux2 #(.DATA_W(DATA_W)) u_stage (
                .sel  (sel[SEL_W-1-d]),
                .in_a (node[2*K+2]),
                .in_b (node[2*K+1]),
                .out  (node[K]),
                .viol (viol[K])
            );
        end
    end

    assign out      = node[0];
    assign any_viol = |viol;
endmodule

// File: rtl/sel_track.sv
// Captures the primary select of an operation and, in the following
// (recovery) cycle, compares it with the late select copy from outside.
// Assumes the late copy is only meaningful in that recovery cycle.
module sel_track #(
    parameter int unsigned SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [SEL_W-1:0] sel,
    input  logic [SEL_W-1:0] sel_dly,
    output logic             err
);
    logic             win_q;
    logic [SEL_W-1:0] sel_q;

    // Open the recovery window and hold the select for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q <= 1'b0;
            sel_q <= '0;
        end else begin
            win_q <= go;
            sel_q <= sel;
        end
    end

    // Flag a disagreement only while the window is open.
    assign err = win_q && (sel_dly != sel_q);
endmodule

// File: rtl/bitline_seg_steer.sv
// Top of the segmented bit-line steering block: registered write demux,
// tree read mux with clear-state checking, and late-select tracking on
// both sides. Each operation is evaluated in one cycle and recovered in
// the next; a new operation may start every cycle.
module bitline_seg_steer #(
    parameter int unsigned DATA_W = bls_pkg::BLS_DATA_W,
    parameter int unsigned SEL_W  = bls_pkg::BLS_SEL_W,
    localparam int unsigned NUM_SEG = 1 << SEL_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_go,
    input  logic [SEL_W-1:0]          wr_sel,
    input  logic [DATA_W-1:0]         wr_data,
    input  logic [SEL_W-1:0]          wr_sel_dly,
    output logic [NUM_SEG*DATA_W-1:0] seg_wr_data,
    output logic                      wr_dly_err,
    input  logic                      rd_go,
    input  logic [SEL_W-1:0]          rd_sel,
    input  logic [SEL_W-1:0]          rd_sel_dly,
    input  logic [NUM_SEG*DATA_W-1:0] seg_rd_data,
    output logic [DATA_W-1:0]         rd_data,
    output logic                      rd_clr_err,
    output logic                      rd_dly_err
);
    logic [DATA_W-1:0] tree_out;
    logic              tree_viol;
    logic [DATA_W-1:0] rd_data_q;
    logic              rd_err_q;

    seg_wr_demux #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_wr_demux (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (wr_go),
        .sel     (wr_sel),
        .data    (wr_data),
        .seg_out (seg_wr_data)
    );

    seg_rd_tree #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_rd_tree (
        .sel      (rd_sel),
        .seg_in   (seg_rd_data),
        .out      (tree_out),
        .any_viol (tree_viol)
    );

    // Register the read word and its clear-state verdict for the recovery cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data_q <= '0;
            rd_err_q  <= 1'b0;
        end else begin
            rd_data_q <= rd_go ? tree_out : '0;
            rd_err_q  <= rd_go && tree_viol;
        end
    end

    assign rd_data    = rd_data_q;
    assign rd_clr_err = rd_err_q;

    sel_track #(.SEL_W(SEL_W)) u_wr_track (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (wr_go),
        .sel     (wr_sel),
        .sel_dly (wr_sel_dly),
        .err     (wr_dly_err)
    );

    sel_track #(.SEL_W(SEL_W)) u_rd_track (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (rd_go),
        .sel     (rd_sel),
        .sel_dly (rd_sel_dly),
        .err     (rd_dly_err)
    );
endmodule

// File: rtl/bls_steer_chk.sv
// Checker for bitline_seg_steer: port-level properties over time.
module bls_steer_chk #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned SEL_W  = 2,
    localparam int unsigned NUM_SEG = 1 << SEL_W
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      wr_go,
    input logic [SEL_W-1:0]          wr_sel,
    input logic [DATA_W-1:0]         wr_data,
    input logic [SEL_W-1:0]          wr_sel_dly,
    input logic [NUM_SEG*DATA_W-1:0] seg_wr_data,
    input logic                      wr_dly_err,
    input logic                      rd_go,
    input logic [SEL_W-1:0]          rd_sel,
    input logic [SEL_W-1:0]          rd_sel_dly,
    input logic [NUM_SEG*DATA_W-1:0] seg_rd_data,
    input logic [DATA_W-1:0]         rd_data,
    input logic                      rd_clr_err,
    input logic                      rd_dly_err
);
    logic [NUM_SEG-1:0] wr_nz;
    logic               rd_stray;

    // Per-segment non-zero flags on the write lines.
    always_comb begin
        for (int i = 0; i < NUM_SEG; i++)
            wr_nz[i] = |seg_wr_data[i*DATA_W +: DATA_W];
    end

    // Any read segment other than the selected one holding a set bit.
    always_comb begin
        rd_stray = 1'b0;
        for (int i = 0; i < NUM_SEG; i++)
            if (SEL_W'(i) != rd_sel && (|seg_rd_data[i*DATA_W +: DATA_W]))
                rd_stray = 1'b1;
    end

    p_wr_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_nz));

    p_wr_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_go |=> (seg_wr_data[$past(wr_sel)*DATA_W +: DATA_W] == $past(wr_data)));

    p_wr_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_go |=> (seg_wr_data == '0));

    p_rd_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_go |=> (rd_data == $past(seg_rd_data[rd_sel*DATA_W +: DATA_W])));

    p_rd_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_go |=> (rd_data == '0 && !rd_clr_err));

    p_rd_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_go |=> (rd_clr_err == $past(rd_stray)));

    p_wr_dly_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_go |=> !wr_dly_err);

    p_rd_dly_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_go |=> !rd_dly_err);
endmodule

bind bitline_seg_steer bls_steer_chk #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_go       (wr_go),
    .wr_sel      (wr_sel),
    .wr_data     (wr_data),
    .wr_sel_dly  (wr_sel_dly),
    .seg_wr_data (seg_wr_data),
    .wr_dly_err  (wr_dly_err),
    .rd_go       (rd_go),
    .rd_sel      (rd_sel),
    .rd_sel_dly  (rd_sel_dly),
    .seg_rd_data (seg_rd_data),
    .rd_data     (rd_data),
    .rd_clr_err  (rd_clr_err),
    .rd_dly_err  (rd_dly_err)
);

// File: tb/bitline_seg_steer_tb.sv
// Directed bench for bitline_seg_steer: one task per scenario.
module bitline_seg_steer_tb;
    localparam int W  = 8;
    localparam int SW = 2;
    localparam int NS = 1 << SW;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            wr_go, rd_go;
    logic [SW-1:0]   wr_sel, wr_sel_dly, rd_sel, rd_sel_dly;
    logic [W-1:0]    wr_data;
    logic [NS*W-1:0] seg_wr_data, seg_rd_data;
    logic            wr_dly_err, rd_clr_err, rd_dly_err;
    logic [W-1:0]    rd_data;

    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    bitline_seg_steer #(.DATA_W(W), .SEL_W(SW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .wr_go(wr_go), .wr_sel(wr_sel), .wr_data(wr_data), .wr_sel_dly(wr_sel_dly),
        .seg_wr_data(seg_wr_data), .wr_dly_err(wr_dly_err),
        .rd_go(rd_go), .rd_sel(rd_sel), .rd_sel_dly(rd_sel_dly),
        .seg_rd_data(seg_rd_data), .rd_data(rd_data),
        .rd_clr_err(rd_clr_err), .rd_dly_err(rd_dly_err)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [NS*W-1:0] place(input int idx, input logic [W-1:0] v);
        logic [NS*W-1:0] r = '0;
        r[idx*W +: W] = v;
        return r;
    endfunction

    task automatic idle_inputs();
        wr_go = 0; rd_go = 0; wr_sel = 0; rd_sel = 0;
        wr_sel_dly = 0; rd_sel_dly = 0; wr_data = 0; seg_rd_data = 0;
    endtask

    // R1: reset clears every output even with activity on the inputs.
    task automatic t_reset();
        @(negedge clk);
        rst_n = 0; wr_go = 1; wr_sel = 2; wr_data = 8'h5A;
        rd_go = 1; rd_sel = 1; seg_rd_data = {NS{8'hFF}};
        @(negedge clk);
        @(negedge clk);
        wr_sel_dly = 3; rd_sel_dly = 3;
        #1;
        check("R1 seg_wr_data", seg_wr_data, 0);
        check("R1 rd_data", rd_data, 0);
        check("R1 errors", {rd_clr_err, wr_dly_err, rd_dly_err}, 0);
        idle_inputs();
        rst_n = 1;
        @(negedge clk);
    endtask

    // R2/R7: a write to each segment, with matching late select.
    task automatic t_write_each();
        for (int i = 0; i < NS; i++) begin
            @(negedge clk);
            wr_go = 1; wr_sel = SW'(i); wr_data = 8'h11 * (i + 1);
            @(negedge clk);
            wr_go = 0; wr_sel_dly = SW'(i);
            #1;
            check("R2 write steer", seg_wr_data, place(i, 8'h11 * (i + 1)));
            check("R7 late select match", wr_dly_err, 0);
        end
    endtask

    // R3: no write leaves all segments clear.
    task automatic t_write_idle();
        @(negedge clk);
        wr_go = 0; wr_sel = 1; wr_data = 8'hC3;
        @(negedge clk);
        #1;
        check("R3 idle write cleared", seg_wr_data, 0);
    endtask

    // R4/R6/R8: a clean read from each segment.
    task automatic t_read_each();
        for (int i = 0; i < NS; i++) begin
            @(negedge clk);
            rd_go = 1; rd_sel = SW'(i); seg_rd_data = place(i, 8'hA0 + 8'(i));
            @(negedge clk);
            rd_go = 0; rd_sel_dly = SW'(i); seg_rd_data = '0;
            #1;
            check("R4 read select", rd_data, 8'hA0 + 8'(i));
            check("R6 clean read no error", rd_clr_err, 0);
            check("R8 late select match", rd_dly_err, 0);
        end
    endtask

    // R5: without rd_go the segments are ignored.
    task automatic t_read_idle();
        @(negedge clk);
        rd_go = 0; rd_sel = 2; seg_rd_data = {NS{8'h77}};
        @(negedge clk);
        #1;
        check("R5 idle rd_data", rd_data, 0);
        check("R5 idle no clear error", rd_clr_err, 0);
        seg_rd_data = '0;
    endtask

    // R6: stray bits in the sibling segment and in the far pair.
    task automatic t_clear_violation();
        // Sibling of segment 0 is segment 1 (first-level stage).
        @(negedge clk);
        rd_go = 1; rd_sel = 0; seg_rd_data = place(0, 8'h3C) | place(1, 8'h01);
        @(negedge clk);
        rd_go = 0; seg_rd_data = '0; rd_sel_dly = 0;
        #1;
        check("R6 sibling stray flagged", rd_clr_err, 1);
        check("R4 data with stray", rd_data, 8'h3C);
        // Far pair: select 1, stray in segment 3 (root stage).
        @(negedge clk);
        rd_go = 1; rd_sel = 1; seg_rd_data = place(1, 8'h00) | place(3, 8'h80);
        @(negedge clk);
        rd_go = 0; seg_rd_data = '0; rd_sel_dly = 1;
        #1;
        check("R6 far stray flagged", rd_clr_err, 1);
        // Selected segment alone non-zero never flags.
        @(negedge clk);
        rd_go = 1; rd_sel = 3; seg_rd_data = place(3, 8'hFF);
        @(negedge clk);
        rd_go = 0; seg_rd_data = '0; rd_sel_dly = 3;
        #1;
        check("R6 selected only no flag", rd_clr_err, 0);
    endtask

    // R7/R8: late select mismatch, and idle cycles ignore the late copy.
    task automatic t_late_select();
        @(negedge clk);
        wr_go = 1; wr_sel = 2; wr_data = 8'h42; rd_go = 1; rd_sel = 1;
        @(negedge clk);
        wr_go = 0; rd_go = 0; wr_sel_dly = 3; rd_sel_dly = 0;
        #1;
        check("R7 write late mismatch", wr_dly_err, 1);
        check("R8 read late mismatch", rd_dly_err, 1);
        @(negedge clk);
        wr_sel_dly = 1; rd_sel_dly = 2;
        #1;
        check("R7 idle ignores late select", wr_dly_err, 0);
        check("R8 idle ignores late select", rd_dly_err, 0);
    endtask

    // R9: writes and reads on consecutive cycles.
    task automatic t_back_to_back();
        @(negedge clk);
        wr_go = 1; wr_sel = 0; wr_data = 8'h0B;
        rd_go = 1; rd_sel = 2; seg_rd_data = place(2, 8'h5E);
        @(negedge clk);
        wr_sel_dly = 0; rd_sel_dly = 2;
        wr_go = 1; wr_sel = 3; wr_data = 8'hD4;
        rd_go = 1; rd_sel = 0; seg_rd_data = place(0, 8'h19);
        #1;
        check("R9 first write", seg_wr_data, place(0, 8'h0B));
        check("R9 first read", rd_data, 8'h5E);
        @(negedge clk);
        wr_go = 0; rd_go = 0; seg_rd_data = '0;
        wr_sel_dly = 3; rd_sel_dly = 0;
        #1;
        check("R9 second write", seg_wr_data, place(3, 8'hD4));
        check("R9 second read", rd_data, 8'h19);
        check("R9 late selects", {wr_dly_err, rd_dly_err}, 0);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin : main
        rst_n = 0;
        idle_inputs();
        t_reset();
        t_write_each();
        t_write_idle();
        t_read_each();
        t_read_idle();
        t_clear_violation();
        t_late_select();
        t_back_to_back();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule